// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block performs the configuration step of a scalable vector unit. A single request carries the number of elements the software still wants to process, a 3-bit element-width code and a register-grouping multiplier. The unit first works out how many elements one register group can hold at that width. It then grants an active vector length no larger than that capacity. It latches the width, grouping, granted length and capacity as the current configuration, which later vector operations read from its outputs.

The granted length goes back on a write-back port one cycle after the request is accepted, so a scalar destination can receive it. A request with an unsupported width or multiplier raises an illegal flag on the write-back port and leaves the configuration untouched.

A combinational side port checks a register index against the current grouping. With a multiplier of N, only indices that are a multiple of N name a valid register group.

Top module: `vcfg_unit`

## Requirements
- R1: The element width code maps 000→8, 001→16, 010→32, 011→64 bits. The capacity `cfg_vlmax` equals (VLEN/SEW)×LMUL. With VLEN=256, code 010 and multiplier 1 it is 8.
- R2: `req_lmul` is a plain integer multiplier. Only 1, 2, 4 and 8 are legal, and they are stored as log2 in `cfg_lmul_log2` (0..3). Every other value, including 0, is illegal.
- R3: The granted length is the smaller of `req_avl` and the capacity. A request of 0 grants 0.
- R4: `req_ready` is always high. Each accepted request produces exactly one `wb_valid` pulse in the following cycle, and `wb_len` carries the grant.
- R5: A width code above 011, a width above the ELEN parameter, or an illegal multiplier sets `wb_illegal`=1 and `wb_len`=0, and leaves all `cfg_*` outputs unchanged.
- R6: A legal request updates `cfg_sew`, `cfg_lmul_log2`, `cfg_vl` and `cfg_vlmax` in the same cycle as its write-back, and `wb_len` equals the new `cfg_vl`.
- R7: After reset, `cfg_sew`=000, `cfg_lmul_log2`=0, `cfg_vl`=0, `cfg_vlmax`=VLEN/8 and `wb_valid`=0.
- R8: `chk_ok` is 1 exactly when `chk_idx` is a multiple of the current multiplier (2^`cfg_lmul_log2`).
- R9: Without an accepted request, the configuration holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Unit accepts a request (always 1) |
| req_avl | input | REQ_W | Requested element count |
| req_sew | input | 3 | Element width code |
| req_lmul | input | 4 | Grouping multiplier as an integer |
| wb_valid | output | 1 | Write-back result valid |
| wb_len | output | VL_W | Granted length |
| wb_illegal | output | 1 | Request was rejected |
| cfg_sew | output | 3 | Current width code |
| cfg_lmul_log2 | output | 2 | Current multiplier, log2 |
| cfg_vl | output | VL_W | Current active length |
| cfg_vlmax | output | VL_W | Current group capacity |
| chk_idx | input | IDX_W | Register index to validate |
| chk_ok | output | 1 | Index is group-aligned |

## Verification
Requests are driven with counts below, equal to and above the capacity, and with zero. This separates a correct minimum from one that always passes the request through or always saturates. Each width code is paired with several multipliers, so a swapped or off-by-one shift in the capacity shows up as a wrong value. Illegal widths and multipliers are placed between legal requests, and back-to-back requests are included, so a reject that corrupts the configuration or a lost write-back becomes visible. Alignment queries use aligned and misaligned indices at each grouping.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
   localparam int SEW_CODE_W = 3;
   localparam int LMUL_IN_W  = 4;
   localparam int LMUL_LOG_W = 2;

   typedef struct packed {
      logic                  legal;
      logic [LMUL_LOG_W-1:0] lmul_log2;
   } vcfg_dec_t;
endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
   import vcfg_pkg::*;
#(
   parameter int ELEN = 64
) (
   input  logic [SEW_CODE_W-1:0] sew_code,
   input  logic [LMUL_IN_W-1:0]  lmul_raw,
   output vcfg_dec_t             dec
);
   localparam int ELEN_CODE = $clog2(ELEN) - 3;

   logic sew_ok;
   logic lmul_ok;
   logic [LMUL_LOG_W-1:0] lmul_log2;

   always_comb begin
      sew_ok = (int'(sew_code) <= 3) && (int'(sew_code) <= ELEN_CODE);
   end

   always_comb begin
      lmul_ok   = 1'b1;
      lmul_log2 = '0;
      case (lmul_raw)
         4'd1:    lmul_log2 = 2'd0;
         4'd2:    lmul_log2 = 2'd1;
         4'd4:    lmul_log2 = 2'd2;
         4'd8:    lmul_log2 = 2'd3;
         default: lmul_ok   = 1'b0;
      endcase
   end

   assign dec.legal     = sew_ok & lmul_ok;
   assign dec.lmul_log2 = lmul_log2;
endmodule

// File: rtl/vcfg_vlmax_tbl.sv
module vcfg_vlmax_tbl
   import vcfg_pkg::*;
#(
   parameter  int VLEN = 256,
   localparam int VL_W = $clog2(VLEN) + 1
) (
   input  logic [1:0]            sew_code,
   input  logic [LMUL_LOG_W-1:0] lmul_log2,
   output logic [VL_W-1:0]       vlmax
);
   localparam int N_SEW  = 4;
   localparam int N_LMUL = 4;

   logic [VL_W-1:0] tbl [N_SEW*N_LMUL];

   for (genvar s = 0; s < N_SEW; s++) begin : g_sew
      for (genvar l = 0; l < N_LMUL; l++) begin : g_lmul
         localparam int CAP = (VLEN >> (3 + s)) << l;
         assign tbl[s*N_LMUL + l] = VL_W'(CAP);
      end
   end

   assign vlmax = tbl[{sew_code, lmul_log2}];
endmodule

// File: rtl/vcfg_clamp.sv
module vcfg_clamp #(
   parameter int REQ_W = 32,
   parameter int VL_W  = 9
) (
   input  logic [REQ_W-1:0] avl,
   input  logic [VL_W-1:0]  cap,
   output logic [VL_W-1:0]  grant
);
   logic [REQ_W-1:0] cap_ext;
   logic             below;

   assign cap_ext = REQ_W'(cap);
   assign below   = avl < cap_ext;
   assign grant   = below ? avl[VL_W-1:0] : cap;
endmodule

// File: rtl/vcfg_regcheck.sv
module vcfg_regcheck
   import vcfg_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [LMUL_LOG_W-1:0] lmul_log2,
   input  logic [IDX_W-1:0]      idx,
   output logic                  ok
);
   logic [IDX_W-1:0] low_mask;

   always_comb begin
      low_mask = '0;
      for (int b = 0; b < 3; b++) begin
         if (b < int'(lmul_log2)) low_mask[b] = 1'b1;
      end
   end

   assign ok = (idx & low_mask) == '0;
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter  int VLEN  = 256,
   parameter  int ELEN  = 64,
   parameter  int REQ_W = 32,
   parameter  int NREG  = 32,
   localparam int VL_W  = $clog2(VLEN) + 1,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [REQ_W-1:0]      req_avl,
   input  logic [SEW_CODE_W-1:0] req_sew,
   input  logic [LMUL_IN_W-1:0]  req_lmul,
   output logic                  wb_valid,
   output logic [VL_W-1:0]       wb_len,
   output logic                  wb_illegal,
   output logic [SEW_CODE_W-1:0] cfg_sew,
   output logic [LMUL_LOG_W-1:0] cfg_lmul_log2,
   output logic [VL_W-1:0]       cfg_vl,
   output logic [VL_W-1:0]       cfg_vlmax,
   input  logic [IDX_W-1:0]      chk_idx,
   output logic                  chk_ok
);
   if ((VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("VLEN must be a power of two");
   end
   if (ELEN < 8 || ELEN > 64 || (ELEN & (ELEN - 1)) != 0) begin : g_bad_elen
      $error("ELEN must be 8, 16, 32 or 64");
   end
   if (VLEN < ELEN) begin : g_bad_ratio
      $error("VLEN must be at least ELEN");
   end
   if (REQ_W < VL_W) begin : g_bad_req
      $error("REQ_W must cover the length width");
   end
   if (NREG < 8 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 8");
   end

   localparam logic [VL_W-1:0] RST_VLMAX = VL_W'(VLEN / 8);

   vcfg_dec_t       dec;
   logic [VL_W-1:0] cap_new;
   logic [VL_W-1:0] grant;
   logic            accept;

   assign req_ready = 1'b1;
   assign accept    = req_valid & req_ready;

   vcfg_decode #(.ELEN(ELEN)) u_decode (
      .sew_code (req_sew),
      .lmul_raw (req_lmul),
      .dec      (dec)
   );

   vcfg_vlmax_tbl #(.VLEN(VLEN)) u_cap (
      .sew_code  (req_sew[1:0]),
      .lmul_log2 (dec.lmul_log2),
      .vlmax     (cap_new)
   );

   vcfg_clamp #(.REQ_W(REQ_W), .VL_W(VL_W)) u_clamp (
      .avl   (req_avl),
      .cap   (cap_new),
      .grant (grant)
   );

   vcfg_regcheck #(.IDX_W(IDX_W)) u_regchk (
      .lmul_log2 (cfg_lmul_log2),
      .idx       (chk_idx),
      .ok        (chk_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_sew       <= '0;
         cfg_lmul_log2 <= '0;
         cfg_vl        <= '0;
         cfg_vlmax     <= RST_VLMAX;
      end else if (accept && dec.legal) begin
         cfg_sew       <= req_sew;
         cfg_lmul_log2 <= dec.lmul_log2;
         cfg_vl        <= grant;
         cfg_vlmax     <= cap_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid   <= 1'b0;
         wb_len     <= '0;
         wb_illegal <= 1'b0;
      end else begin
         wb_valid <= accept;
         if (accept) begin
            wb_illegal <= ~dec.legal;
            wb_len     <= dec.legal ? grant : '0;
         end
      end
   end
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
   parameter  int VLEN = 256,
   localparam int VL_W = $clog2(VLEN) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            wb_valid,
   input logic [VL_W-1:0] wb_len,
   input logic            wb_illegal,
   input logic [2:0]      cfg_sew,
   input logic [1:0]      cfg_lmul_log2,
   input logic [VL_W-1:0] cfg_vl,
   input logic [VL_W-1:0] cfg_vlmax,
   input logic            chk_ok
);
   a_r3_vl_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vl <= cfg_vlmax);

   a_r1_cap_power_of_two: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cfg_vlmax) == 1);

   a_r4_wb_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> wb_valid);

   a_r4_no_spurious_wb: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !wb_valid);

   a_r4_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready);

   a_r5_reject_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_illegal) |-> ($stable(cfg_vl) && $stable(cfg_sew)
                                    && $stable(cfg_lmul_log2) && $stable(cfg_vlmax)));

   a_r5_reject_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_illegal) |-> wb_len == '0);

   a_r6_wb_matches_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_illegal) |-> wb_len == cfg_vl);

   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_valid |-> ($stable(cfg_vl) && $stable(cfg_vlmax)));

   a_r8_single_reg_always_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_lmul_log2 == 2'd0) |-> chk_ok);
endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .wb_valid      (wb_valid),
   .wb_len        (wb_len),
   .wb_illegal    (wb_illegal),
   .cfg_sew       (cfg_sew),
   .cfg_lmul_log2 (cfg_lmul_log2),
   .cfg_vl        (cfg_vl),
   .cfg_vlmax     (cfg_vlmax),
   .chk_ok        (chk_ok)
);

// File: tb/tb_vcfg_unit.sv
`timescale 1ns/1ps
module tb_vcfg_unit;
   localparam int VLEN = 256;
   localparam int ELEN = 64;
   localparam int REQ_W = 32;
   localparam int NREG = 32;
   localparam int VL_W = 9;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n;
   logic             req_valid;
   logic             req_ready;
   logic [REQ_W-1:0] req_avl;
   logic [2:0]       req_sew;
   logic [3:0]       req_lmul;
   logic             wb_valid;
   logic [VL_W-1:0]  wb_len;
   logic             wb_illegal;
   logic [2:0]       cfg_sew;
   logic [1:0]       cfg_lmul_log2;
   logic [VL_W-1:0]  cfg_vl;
   logic [VL_W-1:0]  cfg_vlmax;
   logic [4:0]       chk_idx;
   logic             chk_ok;

   vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .REQ_W(REQ_W), .NREG(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_avl(req_avl), .req_sew(req_sew), .req_lmul(req_lmul),
      .wb_valid(wb_valid), .wb_len(wb_len), .wb_illegal(wb_illegal),
      .cfg_sew(cfg_sew), .cfg_lmul_log2(cfg_lmul_log2), .cfg_vl(cfg_vl),
      .cfg_vlmax(cfg_vlmax), .chk_idx(chk_idx), .chk_ok(chk_ok)
   );

   typedef struct {
      int  len;
      bit  ill;
      int  sew;
      int  lml;
      int  vl;
      int  cap;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_sew = 0;
   int m_lml = 0;
   int m_vl  = 0;
   int m_cap = VLEN / 8;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Driver: caller is at a negedge; leaves req_valid high for one edge.
   task automatic send(int avl, int sew, int lmul, string tag);
      exp_t e;
      int lg;
      bit ok;
      ok = 1;
      lg = 0;
      case (lmul)
         1: lg = 0;
         2: lg = 1;
         4: lg = 2;
         8: lg = 3;
         default: ok = 0;
      endcase
      if (sew > 3 || (8 << sew) > ELEN) ok = 0;
      if (ok) begin
         m_sew = sew;
         m_lml = lg;
         m_cap = (VLEN >> (3 + sew)) << lg;
         m_vl  = (avl < m_cap) ? avl : m_cap;
      end
      e.len = ok ? m_vl : 0;
      e.ill = !ok;
      e.sew = m_sew;
      e.lml = m_lml;
      e.vl  = m_vl;
      e.cap = m_cap;
      e.tag = tag;
      q.push_back(e);
      req_valid = 1'b1;
      req_avl   = REQ_W'(avl);
      req_sew   = 3'(sew);
      req_lmul  = 4'(lmul);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && wb_valid) begin
         if (q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R4: actual unexpected write-back expected none");
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " R3 wb_len"}, int'(wb_len), e.len);
            check({e.tag, " R5 wb_illegal"}, int'(wb_illegal), int'(e.ill));
            check({e.tag, " R6 cfg_sew"}, int'(cfg_sew), e.sew);
            check({e.tag, " R2 cfg_lmul_log2"}, int'(cfg_lmul_log2), e.lml);
            check({e.tag, " R6 cfg_vl"}, int'(cfg_vl), e.vl);
            check({e.tag, " R1 cfg_vlmax"}, int'(cfg_vlmax), e.cap);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_avl = '0;
      req_sew = '0;
      req_lmul = 4'd1;
      chk_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 reset state
      check("R7 cfg_sew", int'(cfg_sew), 0);
      check("R7 cfg_lmul_log2", int'(cfg_lmul_log2), 0);
      check("R7 cfg_vl", int'(cfg_vl), 0);
      check("R7 cfg_vlmax", int'(cfg_vlmax), VLEN / 8);
      check("R7 wb_valid", int'(wb_valid), 0);
      check("R4 req_ready", int'(req_ready), 1);

      // R1/R3: e32 m1 above, below, zero, equal
      send(20, 2, 1, "e32m1 over");   idle(1);
      send(5, 2, 1, "e32m1 under");   idle(1);
      send(0, 2, 1, "e32m1 zero");    idle(1);
      send(8, 2, 1, "e32m1 equal");   idle(1);
      // R1 other widths / groupings, back-to-back
      send(1000, 0, 8, "e8m8 big");
      send(32, 1, 2, "e16m2 exact");
      send(7, 3, 1, "e64m1 clamp");
      send(3, 3, 4, "e64m4 under");
      idle(1);
      send(70000, 1, 4, "e16m4 huge"); idle(1);

      // R5 illegal requests between legal ones
      send(5, 2, 3, "lmul3 bad");     idle(1);
      send(5, 2, 0, "lmul0 bad");     idle(1);
      send(5, 4, 1, "sew100 bad");    idle(1);
      send(5, 7, 2, "sew111 bad");
      send(9, 0, 16 % 16, "lmul16 bad");
      send(12, 0, 1, "e8m1 after bad");
      idle(2);

      // R9 idle holds
      check("R9 cfg_vl hold", int'(cfg_vl), m_vl);
      idle(4);
      check("R9 cfg_vl hold later", int'(cfg_vl), m_vl);
      check("R9 cfg_vlmax hold", int'(cfg_vlmax), m_cap);

      // R8 alignment checks
      chk_idx = 5'd7; #1;
      check("R8 m1 idx7", int'(chk_ok), 1);
      send(40, 2, 4, "e32m4 cfg"); idle(1);
      chk_idx = 5'd4; #1;
      check("R8 m4 idx4", int'(chk_ok), 1);
      chk_idx = 5'd6; #1;
      check("R8 m4 idx6", int'(chk_ok), 0);
      chk_idx = 5'd2; #1;
      check("R8 m4 idx2", int'(chk_ok), 0);
      @(negedge clk);
      send(40, 2, 8, "e32m8 cfg"); idle(1);
      chk_idx = 5'd24; #1;
      check("R8 m8 idx24", int'(chk_ok), 1);
      chk_idx = 5'd12; #1;
      check("R8 m8 idx12", int'(chk_ok), 0);
      @(negedge clk);
      send(40, 2, 2, "e32m2 cfg"); idle(1);
      chk_idx = 5'd30; #1;
      check("R8 m2 idx30", int'(chk_ok), 1);
      chk_idx = 5'd31; #1;
      check("R8 m2 idx31", int'(chk_ok), 0);

      idle(3);
      check("R4 queue drained", q.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule